// File: doc/BRIEF.md
# Endpoint Halt and Configuration Controller

This block keeps three bits of state for each endpoint of a small USB device: a halted bit, a data-toggle bit and a FIFO flag. It also tracks the device-level state (default, addressed, configured). Firmware sends it single-cycle command pulses, each with its own endpoint index: set halt, clear halt, reset endpoint, set configured and clear configured. The serial engine sends a transaction-done pulse with an endpoint index. That pulse flips the data PID of the endpoint and marks its FIFO as holding data.

The halted vector goes to the handshake logic, which answers STALL for any endpoint whose bit is set. The toggle vector selects DATA0 (0) or DATA1 (1) for each endpoint. The configured bit tells the rest of the device that a non-zero configuration is active. Every output is registered and reflects a command on the clock edge after the pulse. A synchronous bus-reset input returns everything to its idle values.

Top module: `ep_state_ctrl`

## Requirements
- R1: After rst_n is released, or one cycle after bus_rst is high, every halted bit, toggle bit and FIFO flag reads 0 and dev_configured reads 0. bus_rst overrides every other input in that cycle.
- R2: A set-halt pulse sets ep_halted[i] for the indexed endpoint on the next clock edge and leaves every other endpoint unchanged.
- R3: A reset-endpoint pulse clears ep_halted[i] and ep_fifo_flag[i] and sets ep_toggle[i] to 0 (DATA0) on the next clock edge.
- R4: A clear-halt pulse for endpoint 0 clears only its halted bit, leaving its toggle and FIFO flag as they were. A clear-halt pulse indexed to any other endpoint has no effect.
- R5: A transaction-done pulse for an endpoint that is not halted before the edge inverts its toggle bit and sets its FIFO flag. For an endpoint that is halted, the pulse has no effect.
- R6: For the same endpoint in the same cycle, reset-endpoint takes priority over both set-halt and transaction-done, and set-halt takes priority over clear-halt.
- R7: Any command or transaction index equal to or above NUM_EP changes nothing.
- R8: The device enters the addressed state when addr_assigned is high in the default state, and leaves it when addr_assigned is low. A set-configured pulse in the addressed state sets dev_configured. In any other state the pulse is ignored.
- R9: A clear-configured pulse in the configured state clears dev_configured and returns to the addressed state. In any other state the pulse is ignored. While configured, addr_assigned going low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rst | input | 1 | Synchronous bus reset, clears all state |
| set_halt | input | 1 | Set-halt command pulse |
| set_halt_idx | input | 4 | Endpoint index for set-halt |
| clr_halt | input | 1 | Clear-halt command pulse (acts on endpoint 0 only) |
| clr_halt_idx | input | 4 | Endpoint index for clear-halt |
| rst_ep | input | 1 | Reset-endpoint command pulse |
| rst_ep_idx | input | 4 | Endpoint index for reset-endpoint |
| xact_done | input | 1 | Successful data transaction pulse from the serial engine |
| xact_idx | input | 4 | Endpoint index of the completed transaction |
| addr_assigned | input | 1 | Level: the device holds a non-zero bus address |
| set_cfg | input | 1 | Set-configured command pulse |
| clr_cfg | input | 1 | Clear-configured command pulse |
| ep_halted | output | NUM_EP | Per-endpoint halted (STALL) bits |
| ep_toggle | output | NUM_EP | Per-endpoint data PID, 0 = DATA0, 1 = DATA1 |
| ep_fifo_flag | output | NUM_EP | Per-endpoint FIFO-holds-data flags |
| dev_configured | output | 1 | Device is in the configured state |

## Verification
The bench goes after same-cycle collisions on one endpoint. If reset-endpoint loses to set-halt or to a transaction, the endpoint would stay halted, or come back on DATA1 after being cleared. It drives a transaction into a halted endpoint, where a design that does not gate the pulse would advance the PID of an endpoint that answered STALL. It sends clear-halt to a non-zero endpoint and indexes beyond NUM_EP: a careless decode would release a stall or corrupt an alias. It issues configuration commands in the wrong state and drops the address while configured, where a design without proper state guards would leave or enter the configured state without an explicit command.

// File: rtl/ep_state_pkg.sv
package ep_state_pkg;

  localparam int unsigned IDX_W = 4;

  typedef struct packed {
    logic halted;
    logic toggle;
    logic fifo;
  } ep_slot_t;

  typedef enum logic [1:0] {
    DEV_DEFAULT    = 2'd0,
    DEV_ADDRESSED  = 2'd1,
    DEV_CONFIGURED = 2'd2
  } dev_state_e;

  // Next state of one endpoint slot from its command hits.
  function automatic ep_slot_t slot_next(
    input ep_slot_t cur,
    input logic     set_h,
    input logic     clr_h,
    input logic     rst_e,
    input logic     xact,
    input logic     is_ep0
  );
    ep_slot_t n;
    n = cur;
    if (rst_e) begin
      n = '0;
    end else begin
      if (xact && !cur.halted) begin
        n.toggle = ~cur.toggle;
        n.fifo   = 1'b1;
      end
      if (set_h)
        n.halted = 1'b1;
      else if (clr_h && is_ep0)
        n.halted = 1'b0;
    end
    return n;
  endfunction

  // Next device-level state from the configuration commands.
  function automatic dev_state_e dev_next(
    input dev_state_e cur,
    input logic       addr_ok,
    input logic       set_c,
    input logic       clr_c
  );
    dev_state_e n;
    n = cur;
    case (cur)
      DEV_DEFAULT:    if (addr_ok) n = DEV_ADDRESSED;
      DEV_ADDRESSED:  if (set_c) n = DEV_CONFIGURED;
                      else if (!addr_ok) n = DEV_DEFAULT;
      DEV_CONFIGURED: if (clr_c) n = DEV_ADDRESSED;
      default:        n = DEV_DEFAULT;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/ep_onehot_dec.sv
module ep_onehot_dec import ep_state_pkg::*; #(
  parameter int unsigned NUM_EP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [IDX_W-1:0]  idx,
  output logic [NUM_EP-1:0] hit
);

  for (genvar k = 0; k < NUM_EP; k++) begin : g_dec
    assign hit[k] = en && (idx == IDX_W'(k));
  end

  logic out_of_range;
  assign out_of_range = (32'(idx) >= NUM_EP);

  p_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_of_range |-> (hit == '0));

  p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

endmodule

// File: rtl/ep_slot.sv
module ep_slot import ep_state_pkg::*; #(
  parameter bit IS_EP0 = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_rst,
  input  logic set_hit,
  input  logic clr_hit,
  input  logic rst_hit,
  input  logic xact_hit,
  output logic halted,
  output logic toggle,
  output logic fifo_flag
);

  ep_slot_t cur, nxt;

  always_comb nxt = slot_next(cur, set_hit, clr_hit, rst_hit, xact_hit, IS_EP0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cur <= '0;
    else if (bus_rst) cur <= '0;
    else              cur <= nxt;
  end

  assign halted    = cur.halted;
  assign toggle    = cur.toggle;
  assign fifo_flag = cur.fifo;

  logic clear_any;
  assign clear_any = rst_hit || bus_rst;

  p_set_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hit && !clear_any) |=> halted);

  p_reset_ep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clear_any |=> (!halted && !toggle && !fifo_flag));

  p_halt_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !clear_any) |=> $stable(toggle));

  p_fifo_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_flag && !clear_any) |=> fifo_flag);

  if (!IS_EP0) begin : g_chk_nonzero
    p_no_clr_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !clear_any) |=> halted);
  end else begin : g_chk_ep0
    p_clr_keeps_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && !set_hit && !clear_any && !xact_hit) |=>
        (!halted && $stable(toggle) && $stable(fifo_flag)));
  end

endmodule

// File: rtl/dev_cfg_fsm.sv
module dev_cfg_fsm import ep_state_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_rst,
  input  logic addr_assigned,
  input  logic set_cfg,
  input  logic clr_cfg,
  output logic configured
);

  dev_state_e state, state_nxt;

  always_comb state_nxt = dev_next(state, addr_assigned, set_cfg, clr_cfg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state <= DEV_DEFAULT;
    else if (bus_rst) state <= DEV_DEFAULT;
    else              state <= state_nxt;
  end

  assign configured = (state == DEV_CONFIGURED);

  p_cfg_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(configured) |-> $past(set_cfg));

  p_cfg_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(configured) |-> ($past(clr_cfg) || $past(bus_rst)));

endmodule

// File: rtl/ep_state_ctrl.sv
module ep_state_ctrl import ep_state_pkg::*; #(
  parameter int unsigned NUM_EP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rst,
  input  logic              set_halt,
  input  logic [IDX_W-1:0]  set_halt_idx,
  input  logic              clr_halt,
  input  logic [IDX_W-1:0]  clr_halt_idx,
  input  logic              rst_ep,
  input  logic [IDX_W-1:0]  rst_ep_idx,
  input  logic              xact_done,
  input  logic [IDX_W-1:0]  xact_idx,
  input  logic              addr_assigned,
  input  logic              set_cfg,
  input  logic              clr_cfg,
  output logic [NUM_EP-1:0] ep_halted,
  output logic [NUM_EP-1:0] ep_toggle,
  output logic [NUM_EP-1:0] ep_fifo_flag,
  output logic              dev_configured
);

  logic [NUM_EP-1:0] set_hit, clr_hit, rst_hit, xact_hit;

  ep_onehot_dec #(.NUM_EP(NUM_EP)) i_dec_set (
    .clk(clk), .rst_n(rst_n), .en(set_halt), .idx(set_halt_idx), .hit(set_hit));
  ep_onehot_dec #(.NUM_EP(NUM_EP)) i_dec_clr (
    .clk(clk), .rst_n(rst_n), .en(clr_halt), .idx(clr_halt_idx), .hit(clr_hit));
  ep_onehot_dec #(.NUM_EP(NUM_EP)) i_dec_rst (
    .clk(clk), .rst_n(rst_n), .en(rst_ep), .idx(rst_ep_idx), .hit(rst_hit));
  ep_onehot_dec #(.NUM_EP(NUM_EP)) i_dec_xact (
    .clk(clk), .rst_n(rst_n), .en(xact_done), .idx(xact_idx), .hit(xact_hit));

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    ep_slot #(.IS_EP0(e == 0)) i_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_rst  (bus_rst),
      .set_hit  (set_hit[e]),
      .clr_hit  (clr_hit[e]),
      .rst_hit  (rst_hit[e]),
      .xact_hit (xact_hit[e]),
      .halted   (ep_halted[e]),
      .toggle   (ep_toggle[e]),
      .fifo_flag(ep_fifo_flag[e])
    );
  end

  dev_cfg_fsm i_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_rst      (bus_rst),
    .addr_assigned(addr_assigned),
    .set_cfg      (set_cfg),
    .clr_cfg      (clr_cfg),
    .configured   (dev_configured)
  );

  p_bus_rst_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (ep_halted == '0 && ep_toggle == '0 &&
                 ep_fifo_flag == '0 && !dev_configured));

  p_reset_beats_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ep && set_halt && rst_ep_idx == set_halt_idx && 32'(rst_ep_idx) < NUM_EP)
      |=> (ep_halted == $past(ep_halted & ~rst_hit)));

endmodule

// File: tb/test_ep_state_ctrl.sv
module test_ep_state_ctrl;

  localparam int NEP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rst = 0, set_halt = 0, clr_halt = 0, rst_ep = 0, xact_done = 0;
  logic [3:0] set_halt_idx = 0, clr_halt_idx = 0, rst_ep_idx = 0, xact_idx = 0;
  logic addr_assigned = 0, set_cfg = 0, clr_cfg = 0;
  logic [NEP-1:0] ep_halted, ep_toggle, ep_fifo_flag;
  logic dev_configured;

  always #4 clk = ~clk;

  ep_state_ctrl #(.NUM_EP(NEP)) i_ep_state_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst),
    .set_halt(set_halt), .set_halt_idx(set_halt_idx),
    .clr_halt(clr_halt), .clr_halt_idx(clr_halt_idx),
    .rst_ep(rst_ep), .rst_ep_idx(rst_ep_idx),
    .xact_done(xact_done), .xact_idx(xact_idx),
    .addr_assigned(addr_assigned), .set_cfg(set_cfg), .clr_cfg(clr_cfg),
    .ep_halted(ep_halted), .ep_toggle(ep_toggle),
    .ep_fifo_flag(ep_fifo_flag), .dev_configured(dev_configured));

  // Reference model: plain integers, 0 = default, 1 = addressed, 2 = configured
  int m_halt[NEP];
  int m_tog[NEP];
  int m_fifo[NEP];
  int m_dev;
  int checks = 0;
  int errors = 0;

  function automatic logic [NEP-1:0] pack(input int a[NEP]);
    logic [NEP-1:0] v;
    for (int i = 0; i < NEP; i++) v[i] = (a[i] != 0);
    return v;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < NEP; i++) begin
      m_halt[i] = 0; m_tog[i] = 0; m_fifo[i] = 0;
    end
    m_dev = 0;
  endtask

  task automatic model_edge();
    int old_halt[NEP];
    int nd;
    if (bus_rst) begin
      model_clear();
      return;
    end
    for (int i = 0; i < NEP; i++) old_halt[i] = m_halt[i];
    for (int i = 0; i < NEP; i++) begin
      if (xact_done && int'(xact_idx) == i && old_halt[i] == 0) begin
        m_tog[i] = 1 - m_tog[i];
        m_fifo[i] = 1;
      end
      if (clr_halt && int'(clr_halt_idx) == i && i == 0) m_halt[i] = 0;
      if (set_halt && int'(set_halt_idx) == i) m_halt[i] = 1;
      if (rst_ep && int'(rst_ep_idx) == i) begin
        m_halt[i] = 0; m_tog[i] = 0; m_fifo[i] = 0;
      end
    end
    nd = m_dev;
    if (m_dev == 0 && addr_assigned) nd = 1;
    if (m_dev == 1) nd = set_cfg ? 2 : (addr_assigned ? 1 : 0);
    if (m_dev == 2 && clr_cfg) nd = 1;
    m_dev = nd;
  endtask

  task automatic compare(input string tag);
    checks++;
    if (ep_halted !== pack(m_halt)) begin
      errors++;
      $display("FAIL %s halted actual %b expected %b", tag, ep_halted, pack(m_halt));
    end
    checks++;
    if (ep_toggle !== pack(m_tog)) begin
      errors++;
      $display("FAIL %s toggle actual %b expected %b", tag, ep_toggle, pack(m_tog));
    end
    checks++;
    if (ep_fifo_flag !== pack(m_fifo)) begin
      errors++;
      $display("FAIL %s fifo actual %b expected %b", tag, ep_fifo_flag, pack(m_fifo));
    end
    checks++;
    if (dev_configured !== (m_dev == 2)) begin
      errors++;
      $display("FAIL %s configured actual %b expected %b", tag, dev_configured, m_dev == 2);
    end
  endtask

  // Called at a falling edge with inputs set; samples after the next rising edge.
  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
    bus_rst = 0; set_halt = 0; clr_halt = 0; rst_ep = 0;
    xact_done = 0; set_cfg = 0; clr_cfg = 0;
  endtask

  task automatic xact(input int i, input string tag);
    xact_done = 1; xact_idx = 4'(i); step(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    step("R1");

    // R2: set halt on endpoint 1
    set_halt = 1; set_halt_idx = 1; step("R2");
    // R5: transactions on endpoint 2 flip the PID and set the FIFO flag
    xact(2, "R5"); xact(2, "R5");
    // R5: halted endpoint 1 ignores a transaction
    xact(1, "R5");
    // R4: clear-halt on non-zero endpoint ignored
    clr_halt = 1; clr_halt_idx = 1; step("R4");
    // R3: reset endpoint 1 and endpoint 2
    rst_ep = 1; rst_ep_idx = 1; step("R3");
    xact(2, "R5");
    rst_ep = 1; rst_ep_idx = 2; step("R3");
    // R4: endpoint 0 clear-halt keeps toggle and FIFO flag
    xact(0, "R5");
    set_halt = 1; set_halt_idx = 0; step("R2");
    clr_halt = 1; clr_halt_idx = 0; step("R4");
    // R5: transaction in the same cycle as set-halt still counts
    xact_done = 1; xact_idx = 3; set_halt = 1; set_halt_idx = 3; step("R5");
    // R6: reset wins over set-halt and transaction on endpoint 3
    rst_ep = 1; rst_ep_idx = 3; set_halt = 1; set_halt_idx = 3;
    xact_done = 1; xact_idx = 3; step("R6");
    // R6: set-halt wins over clear-halt on endpoint 0
    set_halt = 1; set_halt_idx = 0; clr_halt = 1; clr_halt_idx = 0; step("R6");
    clr_halt = 1; clr_halt_idx = 0; step("R4");
    // R7: out-of-range indices
    set_halt = 1; set_halt_idx = 5; xact_done = 1; xact_idx = 7;
    rst_ep = 1; rst_ep_idx = 4; step("R7");
    set_halt = 1; set_halt_idx = 15; step("R7");

    // R8: set-configured in default state is ignored
    set_cfg = 1; step("R8");
    addr_assigned = 1; step("R8");
    set_cfg = 1; step("R8");
    set_cfg = 1; step("R8");
    // R9: address drop while configured has no effect
    addr_assigned = 0; step("R9");
    step("R9");
    clr_cfg = 1; step("R9");
    clr_cfg = 1; step("R9");
    step("R8");
    set_cfg = 1; step("R8");
    // R8: leaving addressed by dropping the address, then set ignored
    addr_assigned = 1; step("R8");
    set_cfg = 1; step("R8");
    clr_cfg = 1; step("R9");
    addr_assigned = 0; step("R8");
    set_cfg = 1; step("R8");

    // R1: bus reset clears a populated state and overrides commands
    addr_assigned = 1; step("R1");
    set_cfg = 1; step("R1");
    set_halt = 1; set_halt_idx = 2; step("R1");
    xact(1, "R1");
    bus_rst = 1; set_halt = 1; set_halt_idx = 3; xact_done = 1; xact_idx = 0; step("R1");
    addr_assigned = 0; step("R1");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule